// File: doc/BRIEF.md
# Start-of-Frame Timeout and Host-Lost Monitor

This block watches an active bus link for the periodic start-of-frame packets that a host sends. It counts microsecond ticks from the last event that restarts it. If the count reaches a set limit before a new frame start arrives, it raises a one-clock "frame start missed" pulse. The count then starts again from zero, so a host that stays silent causes one pulse per timeout period.

On the first missed frame start, a sticky "host lost" flag is set. The flag stays set through any further misses. It falls when a frame start is seen, when the link leaves the active state, or when a bus reset is signalled. A clear always wins over a set that falls in the same clock.

The surrounding link logic supplies a frame-start strobe, the link-active level, a bus-reset level and a one-microsecond tick strobe. All inputs are synchronous to `clk`. The timeout is a parameter, `SOF_TIMEOUT`, counted in ticks, with a default of 1023.

Top module: `sof_watchdog`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the tick count, `sof_missed_o` and `host_lost_o` all go to zero. All three are zero in the cycle after reset.
- R2: When no clear condition is present, the tick count rises by one on each clock in which `tick_us_i` is high, and holds otherwise. `sof_missed_o` is high exactly while the count equals `SOF_TIMEOUT`, so it appears after `SOF_TIMEOUT` ticks with no clear.
- R3: `sof_missed_o` is high for a single clock at a time.
- R4: After a miss pulse the count restarts from zero. A silent host with a tick on every clock therefore gives exactly one pulse every `SOF_TIMEOUT`+1 clocks.
- R5: A clock with `sof_seen_i` high returns the count to zero.
- R6: While `link_up_i` is low, the count is held at zero and no miss pulse occurs.
- R7: A clock with `bus_reset_i` high returns the count to zero.
- R8: A miss pulse with no clear condition in the same clock sets `host_lost_o` on the next clock.
- R9: Once set, `host_lost_o` stays high through further miss pulses and ticks until a clear condition occurs.
- R10: `host_lost_o` is low on the clock after any clock with `sof_seen_i` high, `link_up_i` low or `bus_reset_i` high. This holds even when a miss pulse is present in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_seen_i | input | 1 | One-clock strobe: a start-of-frame packet was received |
| link_up_i | input | 1 | Level: the link is in an active state |
| bus_reset_i | input | 1 | Level: a bus reset is in progress |
| tick_us_i | input | 1 | One-clock strobe every microsecond |
| sof_missed_o | output | 1 | One-clock pulse: the timeout elapsed with no frame start |
| host_lost_o | output | 1 | Sticky flag: at least one frame start was missed since the last clear |

## Verification
The bound checker tests the per-cycle relations on every clock. These are the zeroing of the count by each clear source and by a miss, the hold of the count between ticks, the one-clock width of the miss pulse, and the set, hold and priority-clear rules of the host-lost flag. Some behaviour needs a sequence of cycles, and only the bench scenarios can show it. That covers the exact number of ticks before the first pulse, the regular pulse spacing with a silent host, a clear that falls in the same clock as a miss, and long random mixes of ticks, frame starts, link drops and resets. The bench compares these against a tick-accurate model.

// File: rtl/sof_watchdog_pkg.sv
package sof_watchdog_pkg;

    // One clock's worth of link events seen by the monitor.
    typedef struct packed {
        logic sof;       // frame start received
        logic link_up;   // link is active
        logic bus_reset; // bus reset in progress
        logic tick;      // microsecond strobe
    } link_ev_t;

    // Decisions taken for the host-lost flag in one clock.
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_op_e;

    // Any event that restarts frame timing and drops the host-lost flag.
    function automatic logic ev_restart(link_ev_t ev);
        return ev.sof | ~ev.link_up | ev.bus_reset;
    endfunction

    // Flag decision: a clear outranks a set.
    function automatic flag_op_e flag_decide(link_ev_t ev, logic missed, logic flag_now);
        if (ev_restart(ev)) begin
            return FLAG_CLEAR;
        end else if (missed && !flag_now) begin
            return FLAG_SET;
        end
        return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/sof_tick_timer.sv
module sof_tick_timer
    import sof_watchdog_pkg::*;
#(
    parameter int unsigned LIMIT_TICKS = 1023,
    parameter int unsigned CNT_W       = $clog2(LIMIT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  link_ev_t         ev,
    output logic             expired,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LIMIT_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign expired = (cnt_q == LIMIT);

    always_comb begin
        cnt_d = cnt_q;
        if (expired || ev_restart(ev)) begin
            cnt_d = '0;
        end else if (ev.tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/host_lost_flag.sv
module host_lost_flag
    import sof_watchdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  link_ev_t ev,
    input  logic     missed,
    output logic     lost
);

    logic     lost_q;
    flag_op_e op;

    always_comb begin
        op = flag_decide(ev, missed, lost_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= 1'b0;
        end else begin
            unique case (op)
                FLAG_SET:   lost_q <= 1'b1;
                FLAG_CLEAR: lost_q <= 1'b0;
                default:    lost_q <= lost_q;
            endcase
        end
    end

    assign lost = lost_q;

endmodule

// File: rtl/sof_watchdog.sv
module sof_watchdog
    import sof_watchdog_pkg::*;
#(
    parameter int unsigned SOF_TIMEOUT = 1023
) (
    input  logic clk,
    input  logic rst,
    input  logic sof_seen_i,
    input  logic link_up_i,
    input  logic bus_reset_i,
    input  logic tick_us_i,
    output logic sof_missed_o,
    output logic host_lost_o
);

    localparam int unsigned CNT_W = $clog2(SOF_TIMEOUT + 1);

    link_ev_t         ev;
    logic             missed;
    logic [CNT_W-1:0] tick_count;

    assign ev = '{sof: sof_seen_i, link_up: link_up_i,
                  bus_reset: bus_reset_i, tick: tick_us_i};

    sof_tick_timer #(
        .LIMIT_TICKS (SOF_TIMEOUT),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .expired (missed),
        .count   (tick_count)
    );

    host_lost_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .missed (missed),
        .lost   (host_lost_o)
    );

    assign sof_missed_o = missed;

endmodule

// File: rtl/sof_watchdog_chk.sv
module sof_watchdog_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             sof_seen_i,
    input logic             link_up_i,
    input logic             bus_reset_i,
    input logic             tick_us_i,
    input logic             sof_missed_o,
    input logic             host_lost_o,
    input logic [CNT_W-1:0] tick_count
);

    logic restart;
    assign restart = sof_seen_i | ~link_up_i | bus_reset_i;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!host_lost_o && !sof_missed_o && tick_count == '0)); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_us_i && !restart && !sof_missed_o) |=> $stable(tick_count)); // R2

    AST_MISS_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        sof_missed_o |=> !sof_missed_o); // R3

    AST_RESTART_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        sof_missed_o |=> (tick_count == '0)); // R4

    AST_SOF_ZERO: assert property (@(posedge clk) disable iff (rst)
        sof_seen_i |=> (tick_count == '0)); // R5

    AST_DOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !link_up_i |=> (tick_count == '0 && !sof_missed_o)); // R6

    AST_BUSRST_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> (tick_count == '0)); // R7

    AST_LOST_SET: assert property (@(posedge clk) disable iff (rst)
        (sof_missed_o && !restart) |=> host_lost_o); // R8

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (host_lost_o && !restart) |=> host_lost_o); // R9

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !host_lost_o); // R10

endmodule

bind sof_watchdog sof_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sof_seen_i   (sof_seen_i),
    .link_up_i    (link_up_i),
    .bus_reset_i  (bus_reset_i),
    .tick_us_i    (tick_us_i),
    .sof_missed_o (sof_missed_o),
    .host_lost_o  (host_lost_o),
    .tick_count   (tick_count)
);

// File: tb/sim_sof_watchdog.sv
module sim_sof_watchdog;

    localparam int unsigned TMO = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 1'b0;
    logic up  = 1'b0;
    logic brst = 1'b0;
    logic tick = 1'b0;
    logic missed;
    logic lost;

    int total = 0;
    int bad = 0;
    int m_cnt = 0;
    logic m_lost = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sof_watchdog #(.SOF_TIMEOUT(TMO)) u0 (
        .clk          (clk),
        .rst          (rst),
        .sof_seen_i   (sof),
        .link_up_i    (up),
        .bus_reset_i  (brst),
        .tick_us_i    (tick),
        .sof_missed_o (missed),
        .host_lost_o  (lost)
    );

    function automatic logic exp_missed(int c);
        return (c == TMO);
    endfunction

    function automatic int next_cnt(int c, logic t, logic s, logic a, logic r);
        if (c == TMO || s || !a || r) return 0;
        return t ? c + 1 : c;
    endfunction

    function automatic logic next_lost(logic l, int c, logic s, logic a, logic r);
        if (s || !a || r) return 1'b0;
        if (c == TMO) return 1'b1;
        return l;
    endfunction

    task automatic check(string tag, logic got, logic exp, string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, got, exp);
        end
    endtask

    // Compare outputs with the model, then drive the next clock's inputs.
    task automatic step(logic t, logic s, logic a, logic r, string tag);
        @(negedge clk);
        check(tag, missed, exp_missed(m_cnt), "sof_missed_o");
        check(tag, lost, m_lost, "host_lost_o");
        tick = t; sof = s; up = a; brst = r;
        m_lost = next_lost(m_lost, m_cnt, s, a, r);
        m_cnt  = next_cnt(m_cnt, t, s, a, r);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        up = 1'b1;
        m_cnt = 0;
        m_lost = 1'b0;
        // R1: reset state
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1");

        // R2 and R8: first miss after TMO ticks with gaps, then the flag sets
        for (int i = 0; i < 2 * TMO; i++) step(i[0], 1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R8");

        // R3, R4 and R9: silent host, tick every clock, count the pulses
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
        pulses = 0;
        for (int i = 0; i < 3 * (TMO + 1); i++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0, "R9");
            if (missed === 1'b1) pulses++;
        end
        check("R4", (pulses == 3), 1'b1, "pulse count is 3");

        // R5: SOF midway delays the miss
        for (int i = 0; i < TMO - 2; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
        for (int i = 0; i < TMO - 1; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        check("R5", missed, 1'b0, "no miss before restart window ends");

        // R6: link down holds the count at zero
        for (int i = 0; i < 3 * TMO; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        // R7: bus reset restarts the count
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        for (int i = 0; i < TMO - 2; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R7");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R7");

        // R10: SOF in the very clock of a miss wins over the set
        while (m_cnt != TMO) step(1'b1, 1'b0, 1'b1, 1'b0, "R10");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
        check("R10", lost, 1'b0, "flag after clear-vs-set clock");

        // R10: each clear source drops a set flag
        for (int k = 0; k < 3; k++) begin
            while (m_lost != 1'b1) step(1'b1, 1'b0, 1'b1, 1'b0, "R8");
            step(1'b0, (k == 0), (k != 1), (k == 2), "R10");
            step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
        end

        // Constrained random mix against the model (all requirements)
        for (int i = 0; i < 6000; i++) begin
            logic t, s, a, r;
            t = ($urandom_range(3, 0) != 0);
            s = ($urandom_range(29, 0) == 0);
            a = ($urandom_range(59, 0) != 0);
            r = ($urandom_range(99, 0) == 0);
            step(t, s, a, r, "R2/R9 random");
        end

        // R1: a mid-run reset clears everything
        while (m_lost != 1'b1) step(1'b1, 1'b0, 1'b1, 1'b0, "R8");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0;
        m_lost = 1'b0;
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule